// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Shifter

This block sends a fixed 32-bit identification word, one bit per card-clock pulse, as the synchronous answer to reset of a memory card. The card reset line and card clock are sampled on the system clock. A reset pulse that encloses a rising card-clock edge arms the shifter. The first bit appears when the reset line falls, and each later falling card-clock edge moves to the next bit. After the last bit the block returns to standby and raises a one-cycle completion pulse.

A reset pulse with no card-clock edge inside it sends the block to standby from any state. A pulse that does contain a clock edge restarts the word from its first bit, even in the middle of a stream. No stream starts while a nonvolatile write is in progress. The serial output is qualified by an output-enable, so the pad is high-impedance whenever the block is not streaming.

Top module: `atr_top`

## Requirements
- R1: After system reset, `dout_oe` and `done` are low.
- R2: A stream presents bit k (k = 0..31) of the word 32'h55AA4119 at step k. The bytes therefore go out as 0x19, 0x41, 0xAA, 0x55, each least significant bit first. `dout_oe` is high for the whole stream.
- R3: While streaming, `dout` changes only after a falling edge of `card_clk`. Each falling edge advances by exactly one bit.
- R4: The falling `card_clk` edge that ends bit 31 drops `dout_oe` and produces exactly one `done` pulse.
- R5: A high pulse on `card_rst` that contains a rising `card_clk` edge starts the stream at bit 0 once `card_rst` falls. This holds from standby and from the middle of a stream.
- R6: A high pulse on `card_rst` with no `card_clk` edge inside it leaves the block in standby. `dout_oe` is low and no `done` pulse is produced.
- R7: If `write_busy` is high when `card_rst` falls, no stream starts.
- R8: `dout_oe` is low while `card_rst` is high.
- R9: `card_clk` pulses while the block is in standby leave `dout_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| card_rst | input | 1 | Card reset line |
| card_clk | input | 1 | Card clock line |
| write_busy | input | 1 | High while a nonvolatile write is in progress |
| dout | output | 1 | Serial answer bit |
| dout_oe | output | 1 | Output enable for the serial pad |
| done | output | 1 | One-cycle pulse when the stream completes |

## Verification
A wrong bit index appears at once as a wrong `dout` value at the next sample after a card-clock falling edge. The first wrong position pins down the shift or ordering fault. A stuck or mis-set arming flag appears within three system cycles of `card_rst` falling, as an output-enable that is missing or unexpectedly present. A broken end-of-stream compare appears at the 32nd clock pulse, as a missing `done` pulse or an enable that stays high. Restart and abort faults show at the first sample after the reset pulse: the bench checks there for bit 0 or for a disabled output.

// File: rtl/atr_pkg.sv
package atr_pkg;

    localparam int unsigned RESP_BITS_DEF = 32;
    localparam logic [RESP_BITS_DEF-1:0] RESP_DEF = {8'h55, 8'hAA, 8'h41, 8'h19};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } atr_state_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_ev_t;

endpackage

// File: rtl/atr_edge.sv
module atr_edge
    import atr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     line_in,
    output line_ev_t ev
);
    logic samp_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= line_in;
            prev_q <= samp_q;
        end
    end

    always_comb begin
        ev.lvl  = samp_q;
        ev.rise = samp_q & ~prev_q;
        ev.fall = ~samp_q & prev_q;
    end
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
    import atr_pkg::*;
#(
    parameter int unsigned RESP_BITS = 32,
    localparam int unsigned IDX_W = $clog2(RESP_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         rst_ev,
    input  line_ev_t         cclk_ev,
    input  logic             write_busy,
    output atr_state_e       state,
    output logic [IDX_W-1:0] idx,
    output logic             clk_seen,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RESP_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            clk_seen <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (rst_ev.rise) begin
                        state    <= ST_ARMED;
                        clk_seen <= 1'b0;
                    end
                end
                ST_ARMED: begin
                    if (cclk_ev.rise) clk_seen <= 1'b1;
                    if (rst_ev.fall) begin
                        idx <= '0;
                        if ((clk_seen || cclk_ev.rise) && !write_busy)
                            state <= ST_SEND;
                        else
                            state <= ST_IDLE;
                    end
                end
                ST_SEND: begin
                    if (rst_ev.rise) begin
                        state    <= ST_ARMED;
                        clk_seen <= 1'b0;
                    end else if (cclk_ev.fall) begin
                        if (idx == LAST_IDX) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/atr_bitsel.sv
module atr_bitsel
    import atr_pkg::*;
#(
    parameter int unsigned RESP_BITS = 32,
    parameter logic [RESP_BITS-1:0] RESP = '0,
    localparam int unsigned IDX_W = $clog2(RESP_BITS)
) (
    input  atr_state_e       state,
    input  logic [IDX_W-1:0] idx,
    output logic             dout,
    output logic             dout_oe
);
    always_comb begin
        dout_oe = (state == ST_SEND);
        dout    = dout_oe ? RESP[idx] : 1'b0;
    end
endmodule

// File: rtl/atr_top.sv
module atr_top
    import atr_pkg::*;
#(
    parameter int unsigned RESP_BITS = RESP_BITS_DEF,
    parameter logic [RESP_BITS-1:0] RESP = RESP_DEF,
    localparam int unsigned IDX_W = $clog2(RESP_BITS)
) (
    input  logic clk,
    input  logic rst,
    input  logic card_rst,
    input  logic card_clk,
    input  logic write_busy,
    output logic dout,
    output logic dout_oe,
    output logic done
);
    line_ev_t         rst_ev;
    line_ev_t         cclk_ev;
    atr_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             clk_seen;

    atr_edge u_rst_edge  (.clk(clk), .rst(rst), .line_in(card_rst), .ev(rst_ev));
    atr_edge u_cclk_edge (.clk(clk), .rst(rst), .line_in(card_clk), .ev(cclk_ev));

    atr_ctrl #(.RESP_BITS(RESP_BITS)) u_ctrl (
        .clk(clk), .rst(rst), .rst_ev(rst_ev), .cclk_ev(cclk_ev),
        .write_busy(write_busy), .state(state), .idx(idx),
        .clk_seen(clk_seen), .done(done)
    );

    atr_bitsel #(.RESP_BITS(RESP_BITS), .RESP(RESP)) u_sel (
        .state(state), .idx(idx), .dout(dout), .dout_oe(dout_oe)
    );
endmodule

// File: rtl/atr_chk.sv
module atr_chk
    import atr_pkg::*;
#(
    parameter int unsigned RESP_BITS = 32,
    parameter logic [RESP_BITS-1:0] RESP = '0
) (
    input logic     clk,
    input logic     rst,
    input logic     write_busy,
    input logic     dout,
    input logic     dout_oe,
    input logic     done,
    input logic     clk_seen,
    input line_ev_t rst_ev,
    input line_ev_t cclk_ev
);
    // R8
    oe_off_in_rst_chk: assert property (@(posedge clk) disable iff (rst)
        rst_ev.rise |=> !dout_oe);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && !cclk_ev.fall) |=> (!dout_oe || $stable(dout)));

    // R4
    done_ends_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !dout_oe && $past(dout_oe));

    // R5
    start_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_oe) |-> dout == RESP[0]);

    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_ev.fall && write_busy) |=> !dout_oe);

    // R6
    no_clk_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_ev.fall && !clk_seen && !cclk_ev.rise) |=> !dout_oe && !done);
endmodule

bind atr_top atr_chk #(.RESP_BITS(RESP_BITS), .RESP(RESP)) u_chk (
    .clk(clk), .rst(rst), .write_busy(write_busy), .dout(dout),
    .dout_oe(dout_oe), .done(done), .clk_seen(clk_seen),
    .rst_ev(rst_ev), .cclk_ev(cclk_ev)
);

// File: tb/sim_atr_top.sv
module sim_atr_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EXP_WORD = {8'h55, 8'hAA, 8'h41, 8'h19};
    // {clock inside reset pulse, write_busy at reset fall}
    localparam logic [1:0] SCEN [5] = '{2'b10, 2'b00, 2'b11, 2'b10, 2'b01};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic card_rst = 1'b0;
    logic card_clk = 1'b0;
    logic write_busy = 1'b0;
    logic dout, dout_oe, done;
    int errors = 0;
    int checks = 0;
    int done_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atr_top u0 (.clk(clk), .rst(rst), .card_rst(card_rst), .card_clk(card_clk),
                .write_busy(write_busy), .dout(dout), .dout_oe(dout_oe), .done(done));

    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rst_pulse(input logic with_clk);
        card_rst = 1'b1;
        wait_cyc(4);
        chk("R8 oe during reset pulse", dout_oe, 0);
        if (with_clk) begin
            card_clk = 1'b1; wait_cyc(3);
            card_clk = 1'b0; wait_cyc(3);
        end
        card_rst = 1'b0;
        wait_cyc(4);
    endtask

    task automatic clk_pulse();
        card_clk = 1'b1; wait_cyc(3);
        card_clk = 1'b0; wait_cyc(4);
    endtask

    task automatic read_bits(input int first, input int cnt);
        for (int k = first; k < first + cnt; k++) begin
            chk("R2 oe in stream", dout_oe, 1);
            chk("R2 stream bit", dout, EXP_WORD[k]);
            card_clk = 1'b1; wait_cyc(3);
            chk("R3 bit held while clock high", dout, EXP_WORD[k]);
            card_clk = 1'b0; wait_cyc(4);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int d0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
        chk("R1 oe after reset", dout_oe, 0);
        chk("R1 done after reset", done_cnt, 0);

        for (int s = 0; s < 5; s++) begin
            logic expect_run;
            expect_run = SCEN[s][1] & ~SCEN[s][0];
            write_busy = SCEN[s][0];
            d0 = done_cnt;
            rst_pulse(SCEN[s][1]);
            write_busy = 1'b0;
            if (SCEN[s][0]) chk("R7 busy blocks start", dout_oe, 0);
            else if (!SCEN[s][1]) chk("R6 no clock no start", dout_oe, 0);
            else chk("R5 start after pulse", dout_oe, 1);
            if (expect_run) begin
                read_bits(0, 32);
                chk("R4 oe after last bit", dout_oe, 0);
                chk("R4 one done pulse", done_cnt - d0, 1);
            end else begin
                chk("R6 no done", done_cnt - d0, 0);
            end
        end

        // R9: idle clocks do nothing
        clk_pulse(); clk_pulse();
        chk("R9 idle clocks", dout_oe, 0);

        // R5: restart mid-stream returns to bit 0
        d0 = done_cnt;
        rst_pulse(1'b1);
        read_bits(0, 7);
        rst_pulse(1'b1);
        chk("R5 restart no done", done_cnt - d0, 0);
        read_bits(0, 32);
        chk("R4 done after restart", done_cnt - d0, 1);

        // R6: abort mid-stream
        d0 = done_cnt;
        rst_pulse(1'b1);
        read_bits(0, 12);
        rst_pulse(1'b0);
        chk("R6 abort oe", dout_oe, 0);
        clk_pulse();
        chk("R6 abort stays idle", dout_oe, 0);
        chk("R6 abort no done", done_cnt - d0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule